// File: doc/BRIEF.md
# Dual-Port Byte Mailbox Register File

This block is a small shared register file of eight bytes placed between a 32-bit host bus and the 8-bit I/O port of a communications processor. Each side reaches every byte through its own port, and both ports may act in the same cycle. The two processors pass flags and short messages through it.

The host sees the storage as two 32-bit words, word 0 holding bytes 0..3 and word 1 holding bytes 4..7. A byte in lane k of a word has byte offset n = 4*word + k and sits in bits [8k+7:8k]. Host writes are byte-lane masked and land at the mirrored index n XOR 3. Host reads return byte n in lane k without mirroring. The two host paths are therefore deliberately asymmetric. The 8-bit side addresses the bytes at I/O addresses 0x50..0x57 in natural order. When it reads byte 4 (address 0x54), it sees bit 0 forced high, as a ready/busy indication. The stored value is not changed.

Requests on both ports are plain valid-qualified strobes. There is no ready signal, and every request is taken in the cycle it is presented, so there is no back-pressure. Each read produces exactly one response one cycle later, and the response must be consumed in that cycle because it is not held.

Top module: `byte_mailbox`

## Requirements
- R1: After reset all eight bytes read as 0x00 from the host. From the 8-bit side they read 0x00, except address 0x54, which reads 0x01.
- R2: A host write with lane enable k set, to word w, stores wdata[8k+7:8k] into byte (4w+k) XOR 3.
- R3: A host write leaves unchanged every byte whose source lane enable is clear.
- R4: A host read of word w returns byte 4w+k in rdata[8k+7:8k], with no mirroring and no forced bit.
- R5: An 8-bit-side write to address 0x50+i stores wdata into byte i. An 8-bit-side read of 0x50+i returns byte i.
- R6: An 8-bit-side read of 0x54 returns byte 4 with bit 0 set to 1. The stored byte keeps the written value, as a host read shows.
- R7: An 8-bit-side write to an address outside 0x50..0x57 changes no byte. A read outside that window returns 0x00 with a valid response.
- R8: When both ports write the same byte in one cycle, the host value is stored. When they write different bytes, both updates take effect.
- R9: Each read request yields exactly one response (valid high) in the next cycle on the same port. Response data is zero when valid is low. A read in the same cycle as a write to that byte returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request strobe |
| h_req_write | input | 1 | Host request is a write (1) or a read (0) |
| h_req_word | input | 1 | Host word address |
| h_req_be | input | 4 | Host byte-lane enables for writes |
| h_req_wdata | input | 32 | Host write data |
| h_rsp_valid | output | 1 | Host read response valid |
| h_rsp_rdata | output | 32 | Host read response data |
| p_req_valid | input | 1 | 8-bit side request strobe |
| p_req_write | input | 1 | 8-bit side request is a write (1) or a read (0) |
| p_req_addr | input | 8 | 8-bit side I/O address |
| p_req_wdata | input | 8 | 8-bit side write data |
| p_rsp_valid | output | 1 | 8-bit side read response valid |
| p_rsp_rdata | output | 8 | 8-bit side read response data |

## Verification
A write presented in cycle t is visible to any read presented in cycle t+1 or later. A read presented in cycle t has its response on the port between the edge that ends cycle t and the next edge. The bench drives each request on a falling edge and computes the expected responses from its byte model before applying that cycle's writes. This gives the read-before-write result of R9. It then samples both response ports on the next falling edge, one full cycle after the request. Directed cases cover mirroring, lane masks, the status bit, out-of-window accesses and same-byte collisions, and they are mixed with seeded random traffic on both ports at once.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int MB_NBYTES = 8;
  localparam int MB_LANES  = 4;

  typedef logic [7:0] mb_byte_t;

  // Host writes land at the lane-mirrored position inside a word.
  function automatic int unsigned mirror_index(int unsigned n, int unsigned lanes);
    return n ^ (lanes - 1);
  endfunction

endpackage

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int NBYTES = MB_NBYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBYTES-1:0]      host_we,
  input  mb_byte_t [NBYTES-1:0]  host_d,
  input  logic [NBYTES-1:0]      io_we,
  input  mb_byte_t               io_d,
  output mb_byte_t [NBYTES-1:0]  store_q
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    // Host side has priority on a same-byte collision.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        store_q[b] <= '0;
      end else if (host_we[b]) begin
        store_q[b] <= host_d[b];
      end else if (io_we[b]) begin
        store_q[b] <= io_d;
      end
    end
  end

endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
#(
  parameter int NBYTES = MB_NBYTES,
  parameter int LANES  = MB_LANES,
  localparam int WORDS = NBYTES / LANES,
  localparam int WAW   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int LANEW = $clog2(LANES),
  localparam int IDXW  = $clog2(NBYTES),
  localparam int HW    = LANES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [WAW-1:0]         req_word,
  input  logic [LANES-1:0]       req_be,
  input  logic [HW-1:0]          req_wdata,
  input  mb_byte_t [NBYTES-1:0]  store_q,
  output logic [NBYTES-1:0]      wr_en,
  output mb_byte_t [NBYTES-1:0]  wr_data,
  output logic                   rsp_valid,
  output logic [HW-1:0]          rsp_rdata
);

  logic          rd_fire;
  logic [HW-1:0] rd_next;

  // Write path: each stored byte picks its mirrored source lane.
  for (genvar b = 0; b < NBYTES; b++) begin : g_wr
    localparam int SRC      = int'(mirror_index(b, LANES));
    localparam int SRC_WORD = SRC / LANES;
    localparam int SRC_LANE = SRC % LANES;
    assign wr_en[b]   = req_valid && req_write &&
                        (req_word == WAW'(SRC_WORD)) && req_be[SRC_LANE];
    assign wr_data[b] = req_wdata[SRC_LANE*8 +: 8];
  end

  // Read path: natural order, no mirroring.
  assign rd_fire = req_valid && !req_write;

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    logic [IDXW-1:0] idx;
    if (WORDS > 1) begin : g_multi
      assign idx = {req_word, LANEW'(k)};
    end else begin : g_single
      assign idx = IDXW'(k);
    end
    assign rd_next[k*8 +: 8] = store_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_rdata <= rd_fire ? rd_next : '0;
    end
  end

endmodule

// File: rtl/mbox_io_port.sv
module mbox_io_port
  import mbox_pkg::*;
#(
  parameter int               NBYTES     = MB_NBYTES,
  parameter int               IO_AW      = 8,
  parameter logic [IO_AW-1:0] IO_BASE    = 8'h50,
  parameter int               STATUS_IDX = 4,
  localparam int              IDXW       = $clog2(NBYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [IO_AW-1:0]       req_addr,
  input  mb_byte_t               req_wdata,
  input  mb_byte_t [NBYTES-1:0]  store_q,
  output logic [NBYTES-1:0]      wr_en,
  output mb_byte_t               wr_data,
  output logic                   rsp_valid,
  output mb_byte_t               rsp_rdata
);

  logic            hit;
  logic [IDXW-1:0] idx;
  logic            rd_fire;
  mb_byte_t        rd_next;

  assign hit = (req_addr[IO_AW-1:IDXW] == IO_BASE[IO_AW-1:IDXW]);
  assign idx = req_addr[IDXW-1:0];

  for (genvar b = 0; b < NBYTES; b++) begin : g_wr
    assign wr_en[b] = req_valid && req_write && hit && (idx == IDXW'(b));
  end
  assign wr_data = req_wdata;

  assign rd_fire = req_valid && !req_write;

  always_comb begin
    rd_next = '0;
    if (hit) begin
      rd_next = store_q[idx];
      if (idx == IDXW'(STATUS_IDX)) begin
        rd_next[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_rdata <= rd_fire ? rd_next : '0;
    end
  end

endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox
  import mbox_pkg::*;
#(
  parameter int               NBYTES     = MB_NBYTES,
  parameter int               LANES      = MB_LANES,
  parameter int               IO_AW      = 8,
  parameter logic [IO_AW-1:0] IO_BASE    = 8'h50,
  parameter int               STATUS_IDX = 4,
  localparam int              WORDS      = NBYTES / LANES,
  localparam int              WAW        = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int              HW         = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_req_valid,
  input  logic             h_req_write,
  input  logic [WAW-1:0]   h_req_word,
  input  logic [LANES-1:0] h_req_be,
  input  logic [HW-1:0]    h_req_wdata,
  output logic             h_rsp_valid,
  output logic [HW-1:0]    h_rsp_rdata,
  input  logic             p_req_valid,
  input  logic             p_req_write,
  input  logic [IO_AW-1:0] p_req_addr,
  input  logic [7:0]       p_req_wdata,
  output logic             p_rsp_valid,
  output logic [7:0]       p_rsp_rdata
);

  mb_byte_t [NBYTES-1:0] store_q;
  logic     [NBYTES-1:0] host_we;
  mb_byte_t [NBYTES-1:0] host_d;
  logic     [NBYTES-1:0] io_we;
  mb_byte_t              io_d;

  mbox_host_port #(
    .NBYTES (NBYTES),
    .LANES  (LANES)
  ) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (h_req_valid),
    .req_write (h_req_write),
    .req_word  (h_req_word),
    .req_be    (h_req_be),
    .req_wdata (h_req_wdata),
    .store_q   (store_q),
    .wr_en     (host_we),
    .wr_data   (host_d),
    .rsp_valid (h_rsp_valid),
    .rsp_rdata (h_rsp_rdata)
  );

  mbox_io_port #(
    .NBYTES     (NBYTES),
    .IO_AW      (IO_AW),
    .IO_BASE    (IO_BASE),
    .STATUS_IDX (STATUS_IDX)
  ) u_io (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (p_req_valid),
    .req_write (p_req_write),
    .req_addr  (p_req_addr),
    .req_wdata (p_req_wdata),
    .store_q   (store_q),
    .wr_en     (io_we),
    .wr_data   (io_d),
    .rsp_valid (p_rsp_valid),
    .rsp_rdata (p_rsp_rdata)
  );

  mbox_store #(
    .NBYTES (NBYTES)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_we (host_we),
    .host_d  (host_d),
    .io_we   (io_we),
    .io_d    (io_d),
    .store_q (store_q)
  );

endmodule

// File: rtl/byte_mailbox_checker.sv
module byte_mailbox_checker #(
  parameter int               NBYTES     = 8,
  parameter int               LANES      = 4,
  parameter int               IO_AW      = 8,
  parameter logic [IO_AW-1:0] IO_BASE    = 8'h50,
  parameter int               STATUS_IDX = 4,
  localparam int              IDXW       = $clog2(NBYTES),
  localparam int              HW         = LANES * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_req_valid,
  input logic             h_req_write,
  input logic             h_rsp_valid,
  input logic [HW-1:0]    h_rsp_rdata,
  input logic             p_req_valid,
  input logic             p_req_write,
  input logic [IO_AW-1:0] p_req_addr,
  input logic             p_rsp_valid,
  input logic [7:0]       p_rsp_rdata
);

  logic p_in_window;
  logic p_status_addr;
  assign p_in_window   = (p_req_addr[IO_AW-1:IDXW] == IO_BASE[IO_AW-1:IDXW]);
  assign p_status_addr = p_in_window && (p_req_addr[IDXW-1:0] == IDXW'(STATUS_IDX));

  // R9
  h_rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req_valid && !h_req_write) |=> h_rsp_valid);

  // R9
  h_rsp_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req_valid && !h_req_write) |=> !h_rsp_valid);

  // R9
  p_rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req_valid && !p_req_write) |=> p_rsp_valid);

  // R9
  p_rsp_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_req_valid && !p_req_write) |=> !p_rsp_valid);

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rsp_valid |-> h_rsp_rdata == '0) and (!p_rsp_valid |-> p_rsp_rdata == '0));

  // R6
  status_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req_valid && !p_req_write && p_status_addr) |=> p_rsp_rdata[0]);

  // R7
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req_valid && !p_req_write && !p_in_window) |=> (p_rsp_valid && p_rsp_rdata == 8'h00));

endmodule

bind byte_mailbox byte_mailbox_checker #(
  .NBYTES     (NBYTES),
  .LANES      (LANES),
  .IO_AW      (IO_AW),
  .IO_BASE    (IO_BASE),
  .STATUS_IDX (STATUS_IDX)
) u_byte_mailbox_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .h_req_valid (h_req_valid),
  .h_req_write (h_req_write),
  .h_rsp_valid (h_rsp_valid),
  .h_rsp_rdata (h_rsp_rdata),
  .p_req_valid (p_req_valid),
  .p_req_write (p_req_write),
  .p_req_addr  (p_req_addr),
  .p_rsp_valid (p_rsp_valid),
  .p_rsp_rdata (p_rsp_rdata)
);

// File: tb/byte_mailbox_bench.sv
`timescale 1ns/1ps
module byte_mailbox_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_req_valid, h_req_write, h_req_word;
  logic [3:0]  h_req_be;
  logic [31:0] h_req_wdata;
  logic        h_rsp_valid;
  logic [31:0] h_rsp_rdata;
  logic        p_req_valid, p_req_write;
  logic [7:0]  p_req_addr, p_req_wdata;
  logic        p_rsp_valid;
  logic [7:0]  p_rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] m [8];

  always #2 clk = ~clk;

  byte_mailbox u_byte_mailbox (
    .clk(clk), .rst_n(rst_n),
    .h_req_valid(h_req_valid), .h_req_write(h_req_write), .h_req_word(h_req_word),
    .h_req_be(h_req_be), .h_req_wdata(h_req_wdata),
    .h_rsp_valid(h_rsp_valid), .h_rsp_rdata(h_rsp_rdata),
    .p_req_valid(p_req_valid), .p_req_write(p_req_write), .p_req_addr(p_req_addr),
    .p_req_wdata(p_req_wdata), .p_rsp_valid(p_rsp_valid), .p_rsp_rdata(p_rsp_rdata)
  );

  function automatic logic [31:0] exp_host(input logic w);
    return {m[4*w+3], m[4*w+2], m[4*w+1], m[4*w+0]};
  endfunction

  function automatic logic [7:0] exp_io(input logic [7:0] a);
    logic [7:0] v;
    if (a[7:3] != 5'b01010) return 8'h00;
    v = m[a[2:0]];
    if (a[2:0] == 3'd4) v[0] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives one cycle on both ports (called right after a falling edge),
  // updates the model, and checks the responses one cycle later.
  task automatic step(input string tag,
                      input logic hv, input logic hw, input logic hword,
                      input logic [3:0] hbe, input logic [31:0] hwd,
                      input logic pv, input logic pw,
                      input logic [7:0] pa, input logic [7:0] pwd);
    logic [31:0] eh;
    logic [7:0]  ep;
    h_req_valid = hv; h_req_write = hw; h_req_word = hword;
    h_req_be = hbe; h_req_wdata = hwd;
    p_req_valid = pv; p_req_write = pw; p_req_addr = pa; p_req_wdata = pwd;
    eh = (hv && !hw) ? exp_host(hword) : 32'h0;
    ep = (pv && !pw) ? exp_io(pa) : 8'h00;
    if (pv && pw && pa[7:3] == 5'b01010) m[pa[2:0]] = pwd;
    if (hv && hw) begin
      for (int k = 0; k < 4; k++)
        if (hbe[k]) m[(4*hword + k) ^ 3] = hwd[8*k +: 8];
    end
    @(posedge clk);
    @(negedge clk);
    h_req_valid = 1'b0; p_req_valid = 1'b0;
    check({tag, " host valid"}, {31'd0, h_rsp_valid}, {31'd0, hv && !hw});
    check({tag, " host data"}, h_rsp_rdata, eh);
    check({tag, " io valid"}, {31'd0, p_rsp_valid}, {31'd0, pv && !pw});
    check({tag, " io data"}, {24'd0, p_rsp_rdata}, {24'd0, ep});
  endtask

  task automatic hrd(input string tag, input logic w);
    step(tag, 1, 0, w, 4'h0, 32'h0, 0, 0, 8'h0, 8'h0);
  endtask
  task automatic hwr(input string tag, input logic w, input logic [3:0] be, input logic [31:0] d);
    step(tag, 1, 1, w, be, d, 0, 0, 8'h0, 8'h0);
  endtask
  task automatic prd(input string tag, input logic [7:0] a);
    step(tag, 0, 0, 0, 4'h0, 32'h0, 1, 0, a, 8'h0);
  endtask
  task automatic pwr(input string tag, input logic [7:0] a, input logic [7:0] d);
    step(tag, 0, 0, 0, 4'h0, 32'h0, 1, 1, a, d);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd51966;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    rst_n = 1'b0;
    h_req_valid = 0; h_req_write = 0; h_req_word = 0; h_req_be = 0; h_req_wdata = 0;
    p_req_valid = 0; p_req_write = 0; p_req_addr = 0; p_req_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset host valid", {31'd0, h_rsp_valid}, 32'd0);
    check("R1 reset io valid", {31'd0, p_rsp_valid}, 32'd0);
    rst_n = 1'b1;

    // R1: reset contents
    hrd("R1 word0", 0);
    hrd("R1 word1", 1);
    prd("R1 io 0x50", 8'h50);
    prd("R1 io 0x54", 8'h54);

    // R2: mirrored write lands at index n^3
    hwr("R2 write lane0", 0, 4'b0001, 32'h000000A1);
    hrd("R2 read word0", 0);
    prd("R2 io 0x53", 8'h53);
    // R4: full-word write then unmirrored read
    hwr("R4 write word1", 1, 4'b1111, 32'h44332211);
    hrd("R4 read word1", 1);
    // R6: forced bit only on 8-bit-side read
    prd("R6 io 0x54", 8'h54);
    hrd("R6 host byte4 unforced", 1);
    // R3: masked lanes
    hwr("R3 lane2 only", 0, 4'b0100, 32'hFFEEDDCC);
    hrd("R3 read word0", 0);
    hwr("R3 no lanes", 1, 4'b0000, 32'hDEADBEEF);
    hrd("R3 read word1", 1);
    // R5: natural order on 8-bit side
    pwr("R5 io write 0x52", 8'h52, 8'h5A);
    hrd("R5 host sees byte2", 0);
    pwr("R5 io write 0x57", 8'h57, 8'hC3);
    prd("R5 io read 0x57", 8'h57);
    // R7: outside the window
    pwr("R7 write 0x58", 8'h58, 8'h77);
    pwr("R7 write 0x4F", 8'h4F, 8'h77);
    prd("R7 read 0x4F", 8'h4F);
    prd("R7 read 0xD4", 8'hD4);
    hrd("R7 word0 intact", 0);
    hrd("R7 word1 intact", 1);
    // R8: collisions
    step("R8 same byte", 1, 1, 0, 4'b0001, 32'h000000E1, 1, 1, 8'h53, 8'h1E);
    prd("R8 host won", 8'h53);
    step("R8 diff bytes", 1, 1, 1, 4'b1000, 32'h99000000, 1, 1, 8'h50, 8'h66);
    hrd("R8 word0", 0);
    hrd("R8 word1", 1);
    // R9: read in the same cycle as a write returns the old value
    step("R9 rd-during-wr", 1, 0, 0, 4'h0, 32'h0, 1, 1, 8'h51, 8'h3C);
    step("R9 io rd-during-host-wr", 1, 1, 1, 4'b0010, 32'h0000AB00, 1, 0, 8'h56, 8'h0);
    prd("R9 after write", 8'h56);

    // Random traffic on both ports
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      a = ($urandom % 8 == 0) ? 8'($urandom) : (8'h50 | 8'($urandom % 8));
      step("R9 random", 1'($urandom % 3 != 0), 1'($urandom), 1'($urandom),
           4'($urandom), $urandom, 1'($urandom % 3 != 0), 1'($urandom), a, 8'($urandom));
    end
    hrd("R4 final word0", 0);
    hrd("R4 final word1", 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule